// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

A purely combinational 16-bit adder with carry-in and carry-out. The operand
width is split into four 4-bit groups. Each group forms bit-level generate
(AND) and propagate (OR) terms and computes its internal carries as fully
expanded lookahead products of those terms and the group's carry-in. Each group
also produces a group generate and a group propagate. A second lookahead unit,
which is the same structure applied to the group terms, computes the carry into
every group at once. No carry ripples from one group to the next.

The block also outputs the top-level generate and propagate. A wider adder
can therefore chain several of these blocks under a further lookahead level.
Each sum bit is the XOR of the two operand bits and the carry into that
position. The OR-form propagate cannot be reused for the sum.

Top module: `cla16_adder`

## Requirements
- R1: `sum_o` equals the low 16 bits of `a_i + b_i + carry_in` for every operand pair.
- R2: `carry_out` equals bit 16 of `a_i + b_i + carry_in`.
- R3: `grp_gen_o` is 1 exactly when `a_i + b_i`, with carry-in 0, produces a carry out of bit 15.
- R4: `grp_prop_o` is 1 exactly when every bit position has at least one operand bit set, that is when `(a_i | b_i)` is all ones (OR-form propagate).
- R5: `carry_out` equals `grp_gen_o | (grp_prop_o & carry_in)`.
- R6: The carry entering each 4-bit group (bit positions 4, 8 and 12) equals the carry that a ripple adder produces at that position. This includes a carry that starts in group 0 and must cross every later group.
- R7: All-ones plus all-zeros with carry-in 1 gives sum 0 and carry-out 1. All-ones plus all-ones with carry-in 1 gives sum 0xFFFF and carry-out 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum |
| carry_out | output | 1 | Carry out of bit 15 |
| grp_gen_o | output | 1 | Top-level generate, for cascading |
| grp_prop_o | output | 1 | Top-level OR-form propagate, for cascading |

## Verification
The bench targets carries that must cross group boundaries, such as 0x0FFF + 0 + 1 and 0x000F + 0x0001. In each case a carry from a low group has to be carried by the second-level unit into the groups above it. A design whose group carries ignored the group propagate chain would leave the upper sum bits unchanged.

It drives all-ones operands with carry-in 1 and complementary patterns such as 0x5555 + 0xAAAA. In these cases propagate is 1 while generate is 0. A design that used XOR for propagate, or reused the OR propagate for the sum, would report the wrong cascade flags or the wrong sum bits.

Random vectors are compared with a ripple-carry model written in the bench.

// File: rtl/cla_pkg.sv
`timescale 1ns/1ps
package cla_pkg;
  // Upper bound on the number of terms one lookahead unit can combine.
  localparam int MAXN = 16;

  // Fully expanded lookahead: the carry into position pos is built from
  // generate/propagate terms and the carry-in, with no dependency on
  // any other carry.
  function automatic logic carry_at(input logic [MAXN-1:0] g,
                                    input logic [MAXN-1:0] p,
                                    input logic            cin,
                                    input int              pos);
    logic acc;
    logic run;
    acc = 1'b0;
    for (int j = 0; j <= pos; j++) begin
      run = (j == 0) ? cin : g[j-1];
      for (int k = j; k < pos; k++) begin
        run = run & p[k];
      end
      acc = acc | run;
    end
    return acc;
  endfunction

  function automatic logic all_prop(input logic [MAXN-1:0] p, input int n);
    logic r;
    r = 1'b1;
    for (int k = 0; k < n; k++) r = r & p[k];
    return r;
  endfunction
endpackage

// File: rtl/cla_lookahead_unit.sv
`timescale 1ns/1ps
module cla_lookahead_unit #(
  parameter int N = 4
) (
  input  logic [N-1:0] gen_i,
  input  logic [N-1:0] prop_i,
  input  logic         cin,
  output logic [N-1:0] carry_o,
  output logic         gen_all_o,
  output logic         prop_all_o
);
  import cla_pkg::*;

  logic [MAXN-1:0] g_pad;
  logic [MAXN-1:0] p_pad;

  assign g_pad = {{(MAXN-N){1'b0}}, gen_i};
  assign p_pad = {{(MAXN-N){1'b0}}, prop_i};

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_carry
      assign carry_o[i] = carry_at(g_pad, p_pad, cin, i);
    end
  endgenerate

  assign gen_all_o  = carry_at(g_pad, p_pad, 1'b0, N);
  assign prop_all_o = all_prop(p_pad, N);
endmodule

// File: rtl/cla_group.sv
`timescale 1ns/1ps
module cla_group #(
  parameter int GW = 4
) (
  input  logic [GW-1:0] a_i,
  input  logic [GW-1:0] b_i,
  input  logic          cin,
  output logic [GW-1:0] sum_o,
  output logic          gen_o,
  output logic          prop_o
);
  logic [GW-1:0] bit_gen;
  logic [GW-1:0] bit_prop;
  logic [GW-1:0] bit_carry;

  assign bit_gen  = a_i & b_i;
  assign bit_prop = a_i | b_i;

  cla_lookahead_unit #(.N(GW)) u_bit_la (
    .gen_i      (bit_gen),
    .prop_i     (bit_prop),
    .cin        (cin),
    .carry_o    (bit_carry),
    .gen_all_o  (gen_o),
    .prop_all_o (prop_o)
  );

  // The OR-form propagate is not usable for the sum; use XOR directly.
  assign sum_o = a_i ^ b_i ^ bit_carry;
endmodule

// File: rtl/cla16_adder.sv
`timescale 1ns/1ps
module cla16_adder #(
  parameter int GW = 4,
  parameter int NG = 4
) (
  input  logic [GW*NG-1:0] a_i,
  input  logic [GW*NG-1:0] b_i,
  input  logic             carry_in,
  output logic [GW*NG-1:0] sum_o,
  output logic             carry_out,
  output logic             grp_gen_o,
  output logic             grp_prop_o
);
  import cla_pkg::*;
  localparam int WIDTH = GW * NG;

  logic [NG-1:0] grp_gen;
  logic [NG-1:0] grp_prop;
  logic [NG-1:0] grp_carry;   // carry into each group, brought out for checks

  genvar k;
  generate
    for (k = 0; k < NG; k++) begin : g_grp
      cla_group #(.GW(GW)) u_grp (
        .a_i    (a_i[k*GW +: GW]),
        .b_i    (b_i[k*GW +: GW]),
        .cin    (grp_carry[k]),
        .sum_o  (sum_o[k*GW +: GW]),
        .gen_o  (grp_gen[k]),
        .prop_o (grp_prop[k])
      );
    end
  endgenerate

  cla_lookahead_unit #(.N(NG)) u_grp_la (
    .gen_i      (grp_gen),
    .prop_i     (grp_prop),
    .cin        (carry_in),
    .carry_o    (grp_carry),
    .gen_all_o  (grp_gen_o),
    .prop_all_o (grp_prop_o)
  );

  assign carry_out = carry_at({{(MAXN-NG){1'b0}}, grp_gen},
                              {{(MAXN-NG){1'b0}}, grp_prop}, carry_in, NG);
endmodule

// File: rtl/cla16_adder_chk.sv
`timescale 1ns/1ps
module cla16_adder_chk #(
  parameter int GW = 4,
  parameter int NG = 4
) (
  input logic [GW*NG-1:0] a_i,
  input logic [GW*NG-1:0] b_i,
  input logic             carry_in,
  input logic [GW*NG-1:0] sum_o,
  input logic             carry_out,
  input logic             grp_gen_o,
  input logic             grp_prop_o,
  input logic [NG-1:0]    grp_carry
);
  localparam int WIDTH = GW * NG;

  logic [WIDTH:0] full_ref;
  logic [WIDTH:0] nocin_ref;
  logic [NG-1:0]  boundary_ref;
  logic           known;

  always_comb begin
    full_ref  = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, carry_in};
    nocin_ref = {1'b0, a_i} + {1'b0, b_i};
    for (int k = 0; k < NG; k++) begin
      logic [WIDTH:0] mask;
      logic [WIDTH:0] part;
      mask = ({{WIDTH{1'b0}}, 1'b1} << (k*GW)) - 1'b1;
      part = ({1'b0, a_i} & mask) + ({1'b0, b_i} & mask) + {{WIDTH{1'b0}}, carry_in};
      boundary_ref[k] = part[k*GW];
    end
    known = !$isunknown({a_i, b_i, carry_in, sum_o, carry_out,
                         grp_gen_o, grp_prop_o, grp_carry});
  end

  always_comb begin
    if (known) begin
      a_r1_sum_value: assert (sum_o == full_ref[WIDTH-1:0])
        else $error("R1 sum mismatch");
      a_r2_carry_out: assert (carry_out == full_ref[WIDTH])
        else $error("R2 carry-out mismatch");
      a_r3_gen_flag: assert (grp_gen_o == nocin_ref[WIDTH])
        else $error("R3 generate mismatch");
      a_r4_prop_flag: assert (grp_prop_o == (&(a_i | b_i)))
        else $error("R4 propagate mismatch");
      a_r5_cascade: assert (carry_out == (grp_gen_o | (grp_prop_o & carry_in)))
        else $error("R5 cascade relation broken");
      a_r6_group_carry: assert (grp_carry == boundary_ref)
        else $error("R6 group carry mismatch");
    end
  end
endmodule

bind cla16_adder cla16_adder_chk #(.GW(GW), .NG(NG)) u_chk (
  .a_i        (a_i),
  .b_i        (b_i),
  .carry_in   (carry_in),
  .sum_o      (sum_o),
  .carry_out  (carry_out),
  .grp_gen_o  (grp_gen_o),
  .grp_prop_o (grp_prop_o),
  .grp_carry  (grp_carry)
);

// File: tb/cla16_adder_test.sv
`timescale 1ns/1ps
module cla16_adder_test;
  logic        clk = 1'b0;
  logic [15:0] a = '0;
  logic [15:0] b = '0;
  logic        cin = 1'b0;
  logic [15:0] sum;
  logic        cout, gen, prop;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  cla16_adder uut (
    .a_i(a), .b_i(b), .carry_in(cin),
    .sum_o(sum), .carry_out(cout), .grp_gen_o(gen), .grp_prop_o(prop)
  );

  // Ripple-carry reference: returns {carry, sum}.
  function automatic logic [16:0] ripple(input logic [15:0] x, input logic [15:0] y,
                                         input logic c0);
    logic [15:0] s;
    logic c;
    c = c0;
    for (int i = 0; i < 16; i++) begin
      s[i] = x[i] ^ y[i] ^ c;
      c = (x[i] & y[i]) | (x[i] & c) | (y[i] & c);
    end
    return {c, s};
  endfunction

  function automatic logic all_or(input logic [15:0] x, input logic [15:0] y);
    logic r;
    r = 1'b1;
    for (int i = 0; i < 16; i++) r = r & (x[i] | y[i]);
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s a=%h b=%h cin=%0d actual=%h expected=%h", tag, a, b, cin, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] x, input logic [15:0] y, input logic c);
    logic [16:0] r, r0;
    @(negedge clk);
    a = x; b = y; cin = c;
    #1;
    r  = ripple(x, y, c);
    r0 = ripple(x, y, 1'b0);
    check("R1 sum",       {16'h0, sum},     {16'h0, r[15:0]});
    check("R2 carry-out", {31'h0, cout},    {31'h0, r[16]});
    check("R3 generate",  {31'h0, gen},     {31'h0, r0[16]});
    check("R4 propagate", {31'h0, prop},    {31'h0, all_or(x, y)});
    check("R5 cascade",   {31'h0, cout},    {31'h0, r0[16] | (all_or(x, y) & c)});
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      fails = fails + 1;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    // Idle/zero state (R1)
    apply(16'h0000, 16'h0000, 1'b0);
    // R6: carries crossing group boundaries
    apply(16'h0FFF, 16'h0000, 1'b1);   // sum 0x1000
    apply(16'h000F, 16'h0001, 1'b0);   // sum 0x0010
    apply(16'h00FF, 16'h0001, 1'b0);
    apply(16'h0FF0, 16'h0010, 1'b0);
    apply(16'h7FFF, 16'h0001, 1'b0);   // sum 0x8000, no carry-out
    // R7: all-ones corners
    apply(16'hFFFF, 16'h0000, 1'b1);   // sum 0, cout 1, gen 0, prop 1
    apply(16'hFFFF, 16'hFFFF, 1'b1);   // sum FFFF, cout 1
    apply(16'hFFFF, 16'h0000, 1'b0);   // sum FFFF, cout 0
    check("R7 all-ones no-cin sum", {16'h0, sum}, 32'h0000FFFF);
    // R4/R3: propagate without generate
    apply(16'h5555, 16'hAAAA, 1'b0);
    apply(16'h5555, 16'hAAAA, 1'b1);
    apply(16'h8000, 16'h8000, 1'b0);   // gen 1, prop 0
    // Random vectors
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom();
      apply(r[15:0], r[31:16], $urandom() % 2 == 1);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule